// File: doc/BRIEF.md
# Dual-Output Compare-Match PWM Timer

This block is a single timer channel that produces two pulse-width-modulated pins from one shared 16-bit up-counter and one shared clock prescaler. Four 16-bit compare registers are grouped into two pairs: the first register of each pair marks the period point, the second marks the duty point. A pin rises when the counter meets the pair's period value and falls when it meets the duty value. One of the two period registers is picked to reset the counter, which fixes the cycle length for both pins.

Software configures the channel through a write-only register port: a control byte for the prescale code and the clear source, a mode byte, one output-enable byte per pin, a run bit, and the four compare values. The control byte is locked while the channel runs. A pin whose enable is off is released to high impedance. The level behind each pin is also visible as a plain output.

Top module: `dual_cmp_pwm`

## Requirements
- R1: After reset both pin levels are 0, both output enables are 0, the run bit is 0, and the counter and prescaler are at 0.
- R2: While running, the counter steps up by one on each count-clock tick and holds its value between ticks.
- R3: The control register (address 0) takes the prescale code in bits 1:0 and the clear source in bit 2 (0 = period of pair A, 1 = period of pair C). The count clock ticks once every 4^code clock cycles (1, 4, 16 or 64). After the run bit is written with code 0 and a pair-A period of 3, the pair-A level first reads 1 four cycles after the write edge. With code 1 it first reads 1 sixteen cycles after the write edge.
- R4: On a tick where the counter equals the selected period register, the counter goes to 0 instead of stepping. One PWM cycle then lasts (P+1)·4^code clock cycles.
- R5: A write to the control register while the run bit (address 4, bit 0) is 1 is ignored. The same write is accepted while the channel is stopped.
- R6: Clearing the run bit freezes the counter, the prescaler phase and both levels. Setting it again resumes from the frozen state with the same waveform.
- R7: Compare registers sit at addresses 8 to 11 (A period, A duty, C period, C duty). On a tick where the counter equals a pair's period value, its level is set. On a tick where the counter equals its duty value, the level is cleared. When both match, the period match wins. For a pair whose period is the clear source and 0 < D < P, the level is 1 for (D+1)·4^code cycles of every (P+1)·4^code.
- R8: A duty value greater than or equal to the period value keeps the level at 1 through the whole cycle. A duty value of 0 keeps it at 0.
- R9: Bit 0 at address 2 enables the pair-A pin, and bit 0 at address 3 enables the pair-C pin. An enabled pin carries its level, and its enable output reads 1. A disabled pin is high impedance, and its enable output reads 0.
- R10: Bit 0 of the mode register (address 1) selects PWM mode. With it at 0 both levels are held at 0 while the counter keeps running.
- R11: Both pairs compare against the same counter. A pair that is not the clear source still sets and clears its level at its own compare values within the shared cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 16 | Register write data |
| outLvl | output | 2 | Waveform level per pair (bit 0 = pair A, bit 1 = pair C) |
| outEn | output | 2 | Output enable per pin |
| pinA | output | 1 | Pair-A PWM pin, high impedance when disabled |
| pinC | output | 1 | Pair-C PWM pin, high impedance when disabled |

## Verification
A register write is captured on the edge where the strobe is seen. Enables, mode and run take effect in the following cycle. The count clock adds a delay of 4^code cycles minus one before each counter step, and each level follows the counter tick on which its match occurs, one register later. The bench therefore measures first-rise delays as exact cycle counts from the write edge (4 and 16 for the two prescale cases). It judges duty only after a warm-up of two full PWM cycles, counting high samples at falling clock edges over a window of exactly one cycle length, so the result does not depend on where the window starts. Freeze, lock and mode checks sample only after the write that causes them has been registered.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;

  // Number of output pairs and compare registers (two per pair)
  localparam int N_PAIRS = 2;
  localparam int N_CMP   = 2 * N_PAIRS;

  // Register addresses
  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_OUT0 = 2;
  localparam int A_OUT1 = 3;
  localparam int A_RUN  = 4;
  localparam int A_CMP0 = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;    // one count-clock tick this cycle
    logic clrSel;  // 0: pair A period clears, 1: pair C period clears
    logic pwmOn;   // PWM waveform mode active
  } dpCtl_t;

endpackage

// File: rtl/dcpwm_ctrl.sv
module dcpwm_ctrl
  import dcpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 2,
  parameter int AW  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [CW-1:0]       wrData,
  output dpCtl_t              ctl,
  output logic [CW-1:0]       cmpRegs [N_CMP],
  output logic [N_PAIRS-1:0]  outEnQ,
  output logic                runOn,
  output logic [PSW-1:0]      psSel,
  output logic                clrSel
);

  // Largest divide is 4^(2^PSW-1); prescaler counter width follows
  localparam int MAX_CODE = (1 << PSW) - 1;
  localparam int PCW      = 2 * MAX_CODE;

  logic             pwmOn;
  logic [PCW-1:0]   psCnt;
  logic [PCW-1:0]   psLim;
  logic             tickNow;
  logic             unusedHiBits;

  assign unusedHiBits = ^wrData[CW-1:3];

  // Terminal count of the prescaler for a given code: 4^code - 1
  function automatic logic [PCW-1:0] divLimit(input logic [PSW-1:0] code);
    logic [PCW:0] pow;
    pow = (PCW + 1)'(1) << (2 * code);
    return PCW'(pow - (PCW + 1)'(1));
  endfunction

  function automatic logic hitAddr(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  // Control, mode, enables and run
  always_ff @(posedge clk) begin
    if (!rstN) begin
      psSel  <= '0;
      clrSel <= 1'b0;
      pwmOn  <= 1'b0;
      outEnQ <= '0;
      runOn  <= 1'b0;
    end else if (wrEn) begin
      if (hitAddr(wrAddr, A_CTRL) && !runOn) begin
        psSel  <= wrData[PSW-1:0];
        clrSel <= wrData[2];
      end
      if (hitAddr(wrAddr, A_MODE)) pwmOn     <= wrData[0];
      if (hitAddr(wrAddr, A_OUT0)) outEnQ[0] <= wrData[0];
      if (hitAddr(wrAddr, A_OUT1)) outEnQ[1] <= wrData[0];
      if (hitAddr(wrAddr, A_RUN))  runOn     <= wrData[0];
    end
  end

  // Compare registers, one per address from A_CMP0 up
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpRegs[i] <= '1;
      end else if (wrEn && hitAddr(wrAddr, A_CMP0 + i)) begin
        cmpRegs[i] <= wrData;
      end
    end
  end

  // Prescaler: frozen while stopped, so its phase survives a pause
  assign psLim   = divLimit(psSel);
  assign tickNow = runOn && (psCnt >= psLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (runOn) begin
      psCnt <= tickNow ? '0 : psCnt + PCW'(1);
    end
  end

  always_comb begin
    ctl.tick   = tickNow;
    ctl.clrSel = clrSel;
    ctl.pwmOn  = pwmOn;
  end

endmodule

// File: rtl/dcpwm_dp.sv
module dcpwm_dp
  import dcpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [CW-1:0]      cmpRegs [N_CMP],
  output logic [CW-1:0]      cntVal,
  output logic [N_PAIRS-1:0] outLvl
);

  localparam int CIW = $clog2(N_CMP);

  logic [CIW-1:0] clrIdx;
  logic [CW-1:0]  clrPeriod;
  logic           clrHit;

  // Period register of the selected pair sits at the even index
  assign clrIdx    = CIW'({ctl.clrSel, 1'b0});
  assign clrPeriod = cmpRegs[clrIdx];
  assign clrHit    = (cntVal == clrPeriod);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (ctl.tick) begin
      cntVal <= clrHit ? '0 : cntVal + CW'(1);
    end
  end

  // One waveform generator per pair, all on the shared counter
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    logic [CW-1:0] perVal;
    logic [CW-1:0] dutyVal;
    assign perVal  = cmpRegs[2*p];
    assign dutyVal = cmpRegs[2*p+1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outLvl[p] <= 1'b0;
      end else if (!ctl.pwmOn) begin
        outLvl[p] <= 1'b0;
      end else if (ctl.tick) begin
        if (cntVal == perVal) begin
          // a zero duty never lets the level rise
          outLvl[p] <= (dutyVal != '0);
        end else if (cntVal == dutyVal) begin
          outLvl[p] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dual_cmp_pwm.sv
module dual_cmp_pwm
  import dcpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 2,
  parameter int AW  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [CW-1:0]      wrData,
  output logic [N_PAIRS-1:0] outLvl,
  output logic [N_PAIRS-1:0] outEn,
  output logic               pinA,
  output logic               pinC
);

  dpCtl_t         ctl;
  logic [CW-1:0]  cmpRegs [N_CMP];
  logic           runOn;
  logic [PSW-1:0] psSel;
  logic           clrSel;
  logic [CW-1:0]  cntVal;

  dcpwm_ctrl #(.CW(CW), .PSW(PSW), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ctl     (ctl),
    .cmpRegs (cmpRegs),
    .outEnQ  (outEn),
    .runOn   (runOn),
    .psSel   (psSel),
    .clrSel  (clrSel)
  );

  dcpwm_dp #(.CW(CW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .cmpRegs (cmpRegs),
    .cntVal  (cntVal),
    .outLvl  (outLvl)
  );

  // Disabled pins float
  assign pinA = outEn[0] ? outLvl[0] : 1'bz;
  assign pinC = outEn[1] ? outLvl[1] : 1'bz;

endmodule

// File: rtl/dcpwm_chk.sv
module dcpwm_chk
  import dcpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 2,
  parameter int AW  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [AW-1:0]      wrAddr,
  input logic               runOn,
  input logic               tick,
  input logic               pwmOn,
  input logic [CW-1:0]      cntVal,
  input logic [CW-1:0]      cmpA,
  input logic [CW-1:0]      cmpC,
  input logic               clrSel,
  input logic [PSW-1:0]     psSel,
  input logic [N_PAIRS-1:0] outLvl
);

  logic [CW-1:0] perSel;
  assign perSel = clrSel ? cmpC : cmpA;

  // R2: a step of exactly one on a tick that is not a clear
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntVal != perSel) |=> (cntVal == $past(cntVal) + CW'(1)))
    else $error("a_r2_step");

  // R2: no tick, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(cntVal))
    else $error("a_r2_hold");

  // R4: the selected period match sends the counter to zero
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntVal == perSel) |=> (cntVal == '0))
    else $error("a_r4_clear");

  // R5: control write while running leaves settings untouched
  a_r5_ctrl_lock: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == AW'(A_CTRL) && runOn) |=> ($stable(psSel) && $stable(clrSel)))
    else $error("a_r5_ctrl_lock");

  // R6: stopped channel keeps its count
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !runOn |=> $stable(cntVal))
    else $error("a_r6_freeze");

  // R10: mode off forces both levels low
  a_r10_mode_off: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOn |=> (outLvl == '0))
    else $error("a_r10_mode_off");

endmodule

bind dual_cmp_pwm dcpwm_chk #(.CW(CW), .PSW(PSW), .AW(AW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .runOn  (runOn),
  .tick   (ctl.tick),
  .pwmOn  (ctl.pwmOn),
  .cntVal (cntVal),
  .cmpA   (cmpRegs[0]),
  .cmpC   (cmpRegs[2]),
  .clrSel (clrSel),
  .psSel  (psSel),
  .outLvl (outLvl)
);

// File: tb/dual_cmp_pwm_test.sv
module dual_cmp_pwm_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  outLvl;
  logic [1:0]  outEn;
  logic        pinA;
  logic        pinC;

  int errs = 0;
  int nChk = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_cmp_pwm uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outLvl(outLvl), .outEn(outEn), .pinA(pinA), .pinC(pinC)
  );

  // fields: code, clrSel, A, B, C, D, window, expected high A, expected high C
  localparam int NV = 6;
  localparam int VEC [NV][9] = '{
    '{0, 0,   9, 3, 9, 6,  10,   4,   7},
    '{1, 0,   7, 2, 7, 0,  32,  12,   0},
    '{0, 1, 100, 1, 4, 4,   5,   0,   5},
    '{2, 0,   3, 9, 3, 1,  64,  64,  32},
    '{3, 1,   2, 1, 2, 5, 192, 128, 192},
    '{0, 0,   5, 0, 2, 4,   6,   0,   2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setup(input int ps, input int sel, input int a, input int b,
                       input int c, input int d);
    wr(0, ps | (sel << 2));
    wr(8, a); wr(9, b); wr(10, c); wr(11, d);
    wr(1, 1); wr(2, 1); wr(3, 1);
  endtask

  task automatic measure(input int win, output int hA, output int hC, output int pinBad);
    hA = 0; hC = 0; pinBad = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      hA += int'(outLvl[0]);
      hC += int'(outLvl[1]);
      if (pinA !== outLvl[0] || pinC !== outLvl[1]) pinBad++;
    end
  endtask

  task automatic riseDelay(output int n);
    n = 0;
    while (!outLvl[0] && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errs++; nChk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, nChk);
      $finish;
    end
  end

  initial begin
    int hA, hC, bad, n;

    // R1 reset state
    doReset();
    @(negedge clk);
    check(outLvl == 2'b00, "R1 levels", int'(outLvl), 0);
    check(outEn == 2'b00, "R1 enables", int'(outEn), 0);
    repeat (20) @(negedge clk);
    check(outLvl == 2'b00, "R1 idle stays low", int'(outLvl), 0);

    // Table walk: R4 R7 R8 R11 with pins R9
    for (int v = 0; v < NV; v++) begin
      doReset();
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      wr(4, 1);
      repeat (2 * VEC[v][6] + 8) @(negedge clk);
      measure(VEC[v][6], hA, hC, bad);
      check(hA == VEC[v][7], $sformatf("R7 R8 vec%0d pair A", v), hA, VEC[v][7]);
      check(hC == VEC[v][8], $sformatf("R11 R8 vec%0d pair C", v), hC, VEC[v][8]);
      check(bad == 0, $sformatf("R9 vec%0d pins follow levels", v), bad, 0);
    end

    // R2 R3 first-rise timing, code 0 then code 1
    doReset();
    setup(0, 0, 3, 1, 3, 1);
    wr(4, 1);
    riseDelay(n);
    check(n == 4, "R2 R3 rise delay code0", n, 4);
    doReset();
    setup(1, 0, 3, 1, 3, 1);
    wr(4, 1);
    riseDelay(n);
    check(n == 16, "R2 R3 rise delay code1", n, 16);

    // R5 control locked while running
    doReset();
    setup(0, 0, 9, 3, 9, 6);
    wr(4, 1);
    wr(0, 3);
    repeat (30) @(negedge clk);
    measure(10, hA, hC, bad);
    check(hA == 4, "R5 ctrl write ignored while running", hA, 4);
    wr(4, 0);
    wr(0, 1);
    wr(4, 1);
    repeat (90) @(negedge clk);
    measure(40, hA, hC, bad);
    check(hA == 16, "R5 ctrl write accepted while stopped", hA, 16);

    // R6 freeze and resume
    doReset();
    setup(0, 0, 9, 3, 9, 6);
    wr(4, 1);
    repeat (25) @(negedge clk);
    wr(4, 0);
    begin
      logic [1:0] held;
      int moved;
      held = outLvl; moved = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (outLvl != held) moved++;
      end
      check(moved == 0, "R6 levels frozen while stopped", moved, 0);
    end
    wr(4, 1);
    repeat (30) @(negedge clk);
    measure(10, hA, hC, bad);
    check(hA == 4 && hC == 7, "R6 waveform after resume", hA * 100 + hC, 407);

    // R9 disable pin A, then pin C
    wr(2, 0);
    @(negedge clk);
    check(outEn == 2'b10, "R9 pin A disabled", int'(outEn), 2);
    wr(3, 0);
    @(negedge clk);
    check(outEn == 2'b00, "R9 pin C disabled", int'(outEn), 0);
    wr(2, 1);
    measure(10, hA, hC, bad);
    check(outEn == 2'b01 && pinA === outLvl[0], "R9 pin A re-enabled", int'(outEn), 1);

    // R10 mode off holds levels low
    wr(1, 0);
    measure(20, hA, hC, bad);
    check(hA + hC == 0, "R10 mode off levels low", hA + hC, 0);
    wr(1, 1);
    repeat (25) @(negedge clk);
    measure(10, hA, hC, bad);
    check(hA == 4, "R10 mode back on", hA, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nChk);
    $finish;
  end

endmodule